// File: doc/BRIEF.md
# Edge-Selectable Diagnostic Interrupt Capture

This block samples a word of eleven live diagnostic signals coming from a radio controller, already synchronous to the block clock. It turns chosen transitions on those signals into sticky pending flags. Each signal has its own polarity choice, rising or falling. A transition of the chosen kind sets that signal's pending flag. The flag holds until software clears it.

A per-bit enable word chooses which pending flags drive one interrupt output, and that output is registered. Software uses a simple synchronous register bus with a two-bit address, a write strobe and a combinational read path. Through it, software programs the polarity word and the enable word, acknowledges pending flags by writing ones, and reads back the present level of every monitored signal next to the flags.

Top module: `diag_edge_irq`

## Requirements
- R1: After reset the polarity (address 0), enable (address 1) and pending (address 2) registers read all zeros, and `irq_o` is 0.
- R2: A signal whose polarity bit is 0 sets its pending bit at the first clock edge where the signal is sampled 1 after it was sampled 0. A falling transition leaves that pending bit unchanged.
- R3: A signal whose polarity bit is 1 sets its pending bit at the first clock edge where the signal is sampled 0 after it was sampled 1. A rising transition leaves that pending bit unchanged.
- R4: Only bits 0 to 7 of the polarity register are stored. Bits 8 to 10 read 0 and writes to them are dropped, so signals 8 to 10 always respond to rising transitions.
- R5: A pending bit stays at 1 after its signal goes back to its earlier level, until software clears it.
- R6: Writing to address 2 clears every pending bit whose write-data bit is 1. Write-data bits of 0 leave their pending bits unchanged.
- R7: When a transition event and a clearing write reach the same pending bit at the same clock edge, the bit ends up set.
- R8: `irq_o` equals the OR over all bits of (pending AND enable) as those registers stood one clock edge earlier. An enable bit of 0 keeps its pending bit from raising `irq_o`.
- R9: Reading address 3 returns the present level of `sig_i` in the same cycle. Writes to address 3 change no register.
- R10: The previous-sample register resets to zero, so signals held low through reset and afterwards set no pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_i | input | 11 | Live diagnostic signal word, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 polarity, 1 enable, 2 pending, 3 live |
| wdata | input | 11 | Register write data |
| rdata | output | 11 | Combinational read data for `addr` |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A transition on `sig_i` shows in the pending register at the clock edge that samples it, one edge after the level changes, and `irq_o` follows one edge later. A register write shows on `rdata` right after the edge that takes it, and the live word shows on `rdata` in the same cycle with no edge in between. The bench drives inputs on the falling clock edge, steps its reference model at the rising edge, and compares `rdata` and `irq_o` shortly after the next falling edge. Every check therefore lands in the cycle in which the result is due.

// File: rtl/diag_edge_irq.sv
module diag_edge_irq #(
  parameter int NSIG  = 11,
  parameter int NEDGE = 8,
  parameter int AW    = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] sig_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSIG-1:0] wdata,
  output logic [NSIG-1:0] rdata,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_POL  = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_PEND = AW'(2);
  localparam logic [AW-1:0] A_LIVE = AW'(3);

  logic [NEDGE-1:0] pol_q;
  logic [NSIG-1:0]  en_q, pend_q, prev_q, pol, ev, clr;
  logic             irq_q;

  for (genvar i = 0; i < NSIG; i++) begin : g_pol
    if (i < NEDGE) begin : g_stored
      assign pol[i] = pol_q[i];
    end else begin : g_fixed
      assign pol[i] = 1'b0;
    end
  end

  assign ev  = (sig_i & ~prev_q & ~pol) | (~sig_i & prev_q & pol);
  assign clr = (wr_en && addr == A_PEND) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= sig_i;
      pend_q <= (pend_q & ~clr) | ev;
      irq_q  <= |(pend_q & en_q);
      if (wr_en && addr == A_POL) pol_q <= wdata[NEDGE-1:0];
      if (wr_en && addr == A_EN)  en_q  <= wdata;
    end
  end

  always_comb begin
    case (addr)
      A_POL:   rdata = pol;
      A_EN:    rdata = en_q;
      A_PEND:  rdata = pend_q;
      A_LIVE:  rdata = sig_i;
      default: rdata = '0;
    endcase
  end

  assign irq_o = irq_q;

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_PEND) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_o);

  for (genvar i = 0; i < NSIG; i++) begin : g_chk
    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pol[i] && sig_i[i] && !prev_q[i]) |=> pend_q[i]);
    p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pol[i] && !sig_i[i] && prev_q[i]) |=> pend_q[i]);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PEND && wdata[i] && (sig_i[i] == prev_q[i])) |=> !pend_q[i]);
    p_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PEND && wdata[i] && !pol[i] && sig_i[i] && !prev_q[i]) |=> pend_q[i]);
  end
endmodule

// File: tb/diag_edge_irq_bench.sv
module diag_edge_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] sig_i = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [10:0] wdata = '0;
  logic [10:0] rdata;
  logic        irq_o;

  int checks = 0;
  int fails = 0;
  logic [7:0]  m_pol = '0;
  logic [10:0] m_en = '0, m_pend = '0, m_prev = '0;
  logic        m_irq = 1'b0;

  always #10 clk = ~clk;

  diag_edge_irq u_diag_edge_irq (.clk(clk), .rst_n(rst_n), .sig_i(sig_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  function automatic logic [10:0] exp_rd(input logic [1:0] a, input logic [10:0] s);
    case (a)
      2'd0: return {3'b000, m_pol};
      2'd1: return m_en;
      2'd2: return m_pend;
      default: return s;
    endcase
  endfunction

  function automatic logic [10:0] events(input logic [10:0] s);
    logic [10:0] p;
    p = {3'b000, m_pol};
    return (s & ~m_prev & ~p) | (~s & m_prev & p);
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [10:0] s, input logic w,
                     input logic [1:0] a, input logic [10:0] d);
    logic [10:0] clr;
    sig_i = s; wr_en = w; addr = a; wdata = d;
    #1;
    if (!w) check(tag, rdata, exp_rd(a, s));
    check("R8", {10'd0, irq_o}, {10'd0, m_irq});
    @(posedge clk);
    clr = (w && a == 2'd2) ? d : '0;
    m_irq = |(m_pend & m_en);
    m_pend = (m_pend & ~clr) | events(s);
    m_prev = s;
    if (w && a == 2'd0) m_pol = d[7:0];
    if (w && a == 2'd1) m_en = d;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [10:0] s;
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R1", '0, 0, 2'd0, '0);
    cyc("R1", '0, 0, 2'd1, '0);
    cyc("R10", '0, 0, 2'd2, '0);
    // R2: rising edge on bit 3, sticky after fall (R5)
    cyc("R2", 11'h008, 0, 2'd2, '0);
    cyc("R2", 11'h000, 0, 2'd2, '0);
    check("R2", rdata, 11'h008);
    cyc("R5", 11'h000, 0, 2'd2, '0);
    // R6: zero write no effect, one write clears
    cyc("R6", 11'h000, 1, 2'd2, 11'h7F7);
    cyc("R6", 11'h000, 0, 2'd2, '0);
    check("R6", rdata, 11'h008);
    cyc("R6", 11'h000, 1, 2'd2, 11'h008);
    cyc("R6", 11'h000, 0, 2'd2, '0);
    check("R6", rdata, 11'h000);
    // R4: upper polarity bits not stored
    cyc("R4", 11'h000, 1, 2'd0, 11'h7FF);
    cyc("R4", 11'h000, 0, 2'd0, '0);
    check("R4", rdata, 11'h0FF);
    // R3: falling edges on low bits; R4 rising on bit 9
    cyc("R3", 11'h204, 0, 2'd2, '0);
    cyc("R3", 11'h204, 0, 2'd2, '0);
    check("R4", rdata, 11'h200);
    cyc("R3", 11'h000, 0, 2'd2, '0);
    cyc("R3", 11'h000, 0, 2'd2, '0);
    check("R3", rdata, 11'h204);
    cyc("R3", 11'h000, 1, 2'd2, 11'h7FF);
    cyc("R3", 11'h000, 1, 2'd0, 11'h000);
    // R7: event and clear in the same cycle
    cyc("R7", 11'h001, 1, 2'd2, 11'h001);
    cyc("R7", 11'h001, 0, 2'd2, '0);
    check("R7", rdata, 11'h001);
    // R8: masked then enabled
    cyc("R8", 11'h001, 0, 2'd3, '0);
    cyc("R8", 11'h001, 1, 2'd1, 11'h001);
    cyc("R8", 11'h001, 0, 2'd1, '0);
    cyc("R8", 11'h001, 0, 2'd1, '0);
    check("R8", {10'd0, irq_o}, 11'd1);
    // R9: write to live ignored, live read
    cyc("R9", 11'h5A5, 1, 2'd3, 11'h7FF);
    cyc("R9", 11'h2A2, 0, 2'd3, '0);
    cyc("R9", 11'h2A2, 0, 2'd1, '0);
    for (int n = 0; n < 400; n++) begin
      logic [1:0] a;
      logic       w;
      string      t;
      s = (($urandom % 4) == 0) ? 11'($urandom) : sig_i;
      a = 2'($urandom);
      w = (($urandom % 3) == 0);
      case (a)
        2'd0: t = "R4";
        2'd1: t = "R8";
        2'd2: t = "R5";
        default: t = "R9";
      endcase
      cyc(t, s, w, a, 11'($urandom));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule